// File: doc/BRIEF.md
# MSI Vector-Table Interrupt Dispatcher

This block takes one message-signalled interrupt at a time, described by the write address and the write data, and turns it into an interrupt source number. It checks that number against the configured source count and against the table settings. It then fetches the source's 64-bit vector entry from memory through a request/response read port and decodes the entry's fields: destination server, priority, generation, owning domain, and the pending (P) and queued (Q) bits.

The block keeps no local pending state. The P and Q bits live in memory, and the block changes them with single-byte writes into the entry. The coalescing rule is as follows. An idle source is marked pending and its interrupt goes out on the presentation port. A pending source is marked queued. A source that is already queued drops the event.

A force input is used for retries. Errors are reported on a one-cycle error strobe with a cause code.

Top module: `msi_dispatch`

## Requirements
- R1: The source number is `((msi_addr_i >> 4) & 16'hFFFF) | (msi_data_i & 5'h1F)`. Data bits above bit 4 and address bits outside [19:4] have no effect.
- R2: If the source number is not below `cfg_src_count_i`, no table access is made. `err_valid_o` pulses for one cycle with `err_code_o` = 1.
- R3: If `cfg_tbl_en_i` is low, or the source number is not below `cfg_tbl_len_i`, no table access is made. `err_valid_o` pulses with `err_code_o` = 2. The R2 check takes precedence over this one.
- R4: The entry address is `cfg_tbl_base_i + src*16`, or `+ src*128` when `cfg_big_entry_i` is high. `rd_req_o` holds that address steady until `rd_valid_i` returns the entry on `rd_data_i`.
- R5: Byte k of the entry is bits [8k+7:8k]. The entry fields are:
  - [15:0] raw server
  - [23:16] priority
  - bit 32: P
  - [34:33] generation
  - bit 40: Q
  - [55:48] domain

  With {P,Q} = 00 and priority not 0xFF, the block writes byte `8'h01 | (gen << 1)` at entry address + 4. After `wr_ack_i` it presents the interrupt.
- R6: With {P,Q} = 10 and priority not 0xFF, the block writes byte 0x01 at entry address + 5 and presents nothing.
- R7: With Q = 1 (and no force), the event is dropped: no write, no interrupt, no error.
- R8: A presented interrupt carries `irq_server_o` = raw server >> 2, `irq_num_o` = source + `cfg_src_offset_i`, and `irq_prio_o` = the entry priority. It is held stable until `irq_ready_i`.
- R9: If `msi_dom_i` is not all ones and differs from the entry's domain field, nothing is written or sent, and `err_code_o` = 3 is flagged. A requester domain of 8'hFF skips this check.
- R10: A priority of 0xFF marks the source masked. A masked source that is not dropped by R7 gets Q set (byte 0x01 at +5) and nothing is sent.
- R11: When `msi_force_i` is high, the stored P/Q bits are treated as 00.
- R12: `msi_ready_o` is high only when the block is idle. Only one of ready, read request, write request and interrupt valid is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_valid_i | input | 1 | Incoming MSI valid |
| msi_ready_o | output | 1 | Block idle, MSI accepted when valid |
| msi_addr_i | input | ADDR_W | MSI write address |
| msi_data_i | input | 16 | MSI write data |
| msi_dom_i | input | 8 | Requesting domain, all ones skips check |
| msi_force_i | input | 1 | Treat stored P/Q as 00 |
| cfg_tbl_en_i | input | 1 | Vector table enable |
| cfg_big_entry_i | input | 1 | 128-byte entry stride when high, else 16 |
| cfg_tbl_base_i | input | ADDR_W | Table base address |
| cfg_tbl_len_i | input | 17 | Number of table entries |
| cfg_src_count_i | input | 17 | Number of valid sources |
| cfg_src_offset_i | input | IRQ_W | Added to source for interrupt number |
| rd_req_o | output | 1 | Entry read request |
| rd_addr_o | output | ADDR_W | Entry read address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read response entry |
| wr_req_o | output | 1 | Byte write request |
| wr_addr_o | output | ADDR_W | Byte write address |
| wr_byte_o | output | 8 | Byte value |
| wr_ack_i | input | 1 | Byte write accepted |
| irq_valid_o | output | 1 | Interrupt presentation valid |
| irq_ready_i | input | 1 | Presentation accepted |
| irq_server_o | output | 14 | Destination server |
| irq_num_o | output | IRQ_W | Interrupt number |
| irq_prio_o | output | 8 | Interrupt priority |
| err_valid_o | output | 1 | One-cycle error strobe |
| err_code_o | output | 2 | 1 range, 2 table, 3 domain |

## Verification
The bench covers all four {P,Q} states, and the masked priority with an otherwise idle state. A design that looked at P before Q, or that set P for a masked source, would issue a write at +4 or raise an interrupt where none is due.

It exercises the source-number merge with address bits above bit 19 and data bits above bit 4. A design that kept those bits would read the wrong entry address.

The source-count and table-length bounds are tested with a length smaller than the count, so that the two error codes come apart. Both entry strides are used. The domain check is run in three forms: matching, mismatching and the skip value.

A forced retry of a queued source must set P and send. A stalled presentation must hold its fields until accepted.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int SRC_W     = 16;
  localparam int CNT_W     = SRC_W + 1;
  localparam int DOM_W     = 8;
  localparam int PRIO_W    = 8;
  localparam int RAW_SRV_W = 16;
  localparam int SRV_W     = RAW_SRV_W - 2;
  localparam int GEN_W     = 2;

  // entry field positions (byte k = bits 8k+7:8k)
  localparam int ENT_SRV_LSB  = 0;
  localparam int ENT_PRIO_LSB = 16;
  localparam int ENT_P_BIT    = 32;
  localparam int ENT_GEN_LSB  = 33;
  localparam int ENT_Q_BIT    = 40;
  localparam int ENT_DOM_LSB  = 48;
  localparam int P_BYTE_OFF   = 4;
  localparam int Q_BYTE_OFF   = 5;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_RANGE  = 2'd1,
    ERR_TABLE  = 2'd2,
    ERR_DOMAIN = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    ACT_DROP,
    ACT_SET_Q,
    ACT_SET_P
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_EVAL,
    S_WRITE,
    S_SEND
  } st_e;
endpackage

// File: rtl/msi_src_map.sv
module msi_src_map
  import msi_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic [CNT_W-1:0]  src_count_i,
  input  logic              tbl_en_i,
  input  logic [CNT_W-1:0]  tbl_len_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              big_entry_i,
  output logic [SRC_W-1:0]  src_o,
  output logic              range_ok_o,
  output logic              tbl_ok_o,
  output logic [ADDR_W-1:0] entry_addr_o
);
  localparam int SMALL_SH = 4;
  localparam int BIG_SH   = 7;

  logic [ADDR_W-1:0] src_ext;
  logic              unused_bits;

  assign src_o      = addr_i[4 +: SRC_W] | {{(SRC_W-5){1'b0}}, data_i[4:0]};
  assign range_ok_o = {1'b0, src_o} < src_count_i;
  assign tbl_ok_o   = tbl_en_i && ({1'b0, src_o} < tbl_len_i);
  assign src_ext    = ADDR_W'(src_o);

  assign entry_addr_o = tbl_base_i +
                        (big_entry_i ? (src_ext << BIG_SH) : (src_ext << SMALL_SH));

  assign unused_bits = ^{addr_i[ADDR_W-1:4+SRC_W], addr_i[3:0], data_i[15:5]};
endmodule

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
  import msi_pkg::*;
(
  input  logic [63:0]       entry_i,
  input  logic              force_i,
  input  logic [DOM_W-1:0]  req_dom_i,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [GEN_W-1:0]  gen_o,
  output logic              dom_ok_o,
  output act_e              act_o
);
  logic             p_bit, q_bit;
  logic [DOM_W-1:0] dom;
  logic             unused_bits;

  // low two bits of raw server are a link pointer
  assign server_o = entry_i[ENT_SRV_LSB+2 +: SRV_W];
  assign prio_o   = entry_i[ENT_PRIO_LSB +: PRIO_W];
  assign gen_o    = entry_i[ENT_GEN_LSB +: GEN_W];
  assign p_bit    = entry_i[ENT_P_BIT];
  assign q_bit    = entry_i[ENT_Q_BIT];
  assign dom      = entry_i[ENT_DOM_LSB +: DOM_W];
  assign dom_ok_o = (&req_dom_i) || (dom == req_dom_i);

  always_comb begin
    if (!force_i && q_bit)           act_o = ACT_DROP;
    else if (prio_o == PRIO_MASKED)  act_o = ACT_SET_Q;
    else if (force_i || !p_bit)      act_o = ACT_SET_P;
    else                             act_o = ACT_SET_Q;
  end

  assign unused_bits = ^{entry_i[31:24], entry_i[39:35], entry_i[47:41],
                         entry_i[63:56], entry_i[1:0]};
endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch
  import msi_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IRQ_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_valid_i,
  output logic              msi_ready_o,
  input  logic [ADDR_W-1:0] msi_addr_i,
  input  logic [15:0]       msi_data_i,
  input  logic [7:0]        msi_dom_i,
  input  logic              msi_force_i,
  input  logic              cfg_tbl_en_i,
  input  logic              cfg_big_entry_i,
  input  logic [ADDR_W-1:0] cfg_tbl_base_i,
  input  logic [16:0]       cfg_tbl_len_i,
  input  logic [16:0]       cfg_src_count_i,
  input  logic [IRQ_W-1:0]  cfg_src_offset_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [63:0]       rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_byte_o,
  input  logic              wr_ack_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [13:0]       irq_server_o,
  output logic [IRQ_W-1:0]  irq_num_o,
  output logic [7:0]        irq_prio_o,
  output logic              err_valid_o,
  output logic [1:0]        err_code_o
);
  st_e               state_q;
  logic [SRC_W-1:0]  src_q;
  logic [ADDR_W-1:0] base_q;
  logic [63:0]       entry_q;
  logic              force_q;
  logic [DOM_W-1:0]  dom_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_byte_q;
  logic              send_after_q;
  logic              err_valid_q;
  err_e              err_q;

  logic [SRC_W-1:0]  src;
  logic              range_ok, tbl_ok;
  logic [ADDR_W-1:0] entry_addr;
  logic [SRV_W-1:0]  server;
  logic [PRIO_W-1:0] prio;
  logic [GEN_W-1:0]  gen;
  logic              dom_ok;
  act_e              act;

  msi_src_map #(.ADDR_W(ADDR_W)) u_src_map (
    .addr_i      (msi_addr_i),
    .data_i      (msi_data_i),
    .src_count_i (cfg_src_count_i),
    .tbl_en_i    (cfg_tbl_en_i),
    .tbl_len_i   (cfg_tbl_len_i),
    .tbl_base_i  (cfg_tbl_base_i),
    .big_entry_i (cfg_big_entry_i),
    .src_o       (src),
    .range_ok_o  (range_ok),
    .tbl_ok_o    (tbl_ok),
    .entry_addr_o(entry_addr)
  );

  msi_entry_decode u_decode (
    .entry_i  (entry_q),
    .force_i  (force_q),
    .req_dom_i(dom_q),
    .server_o (server),
    .prio_o   (prio),
    .gen_o    (gen),
    .dom_ok_o (dom_ok),
    .act_o    (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      src_q        <= '0;
      base_q       <= '0;
      entry_q      <= '0;
      force_q      <= 1'b0;
      dom_q        <= '0;
      wr_addr_q    <= '0;
      wr_byte_q    <= '0;
      send_after_q <= 1'b0;
      err_valid_q  <= 1'b0;
      err_q        <= ERR_NONE;
    end else begin
      err_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (msi_valid_i) begin
          src_q   <= src;
          base_q  <= entry_addr;
          force_q <= msi_force_i;
          dom_q   <= msi_dom_i;
          if (!range_ok) begin
            err_valid_q <= 1'b1;
            err_q       <= ERR_RANGE;
          end else if (!tbl_ok) begin
            err_valid_q <= 1'b1;
            err_q       <= ERR_TABLE;
          end else begin
            state_q <= S_READ;
          end
        end
        S_READ: if (rd_valid_i) begin
          entry_q <= rd_data_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (!dom_ok) begin
            err_valid_q <= 1'b1;
            err_q       <= ERR_DOMAIN;
            state_q     <= S_IDLE;
          end else begin
            unique case (act)
              ACT_SET_P: begin
                wr_addr_q    <= base_q + ADDR_W'(P_BYTE_OFF);
                wr_byte_q    <= 8'h01 | {5'b0, gen, 1'b0};
                send_after_q <= 1'b1;
                state_q      <= S_WRITE;
              end
              ACT_SET_Q: begin
                wr_addr_q    <= base_q + ADDR_W'(Q_BYTE_OFF);
                wr_byte_q    <= 8'h01;
                send_after_q <= 1'b0;
                state_q      <= S_WRITE;
              end
              default: state_q <= S_IDLE;
            endcase
          end
        end
        S_WRITE: if (wr_ack_i) state_q <= send_after_q ? S_SEND : S_IDLE;
        S_SEND:  if (irq_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign msi_ready_o  = (state_q == S_IDLE);
  assign rd_req_o     = (state_q == S_READ);
  assign rd_addr_o    = base_q;
  assign wr_req_o     = (state_q == S_WRITE);
  assign wr_addr_o    = wr_addr_q;
  assign wr_byte_o    = wr_byte_q;
  assign irq_valid_o  = (state_q == S_SEND);
  assign irq_server_o = server;
  assign irq_num_o    = IRQ_W'(src_q) + cfg_src_offset_i;
  assign irq_prio_o   = prio;
  assign err_valid_o  = err_valid_q;
  assign err_code_o   = err_q;
endmodule

// File: rtl/msi_dispatch_chk.sv
module msi_dispatch_chk #(
  parameter int ADDR_W = 48,
  parameter int IRQ_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msi_ready_o,
  input logic              rd_req_o,
  input logic              rd_valid_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        wr_byte_o,
  input logic              irq_valid_o,
  input logic              irq_ready_i,
  input logic [IRQ_W-1:0]  irq_num_o,
  input logic [13:0]       irq_server_o,
  input logic              err_valid_o,
  input logic [1:0]        err_code_o
);
  a_r12_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({msi_ready_o, rd_req_o, wr_req_o, irq_valid_o}));

  a_r4_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  a_r5_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_byte_o));

  a_r6_byte_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_byte_o[0]);

  a_r8_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && !irq_ready_i |=> irq_valid_o && $stable(irq_num_o) && $stable(irq_server_o));

  a_r2_err_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> err_code_o != 2'd0);

  a_r12_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> msi_ready_o);

  a_r12_send_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_ready_i |=> msi_ready_o);
endmodule

bind msi_dispatch msi_dispatch_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msi_ready_o (msi_ready_o),
  .rd_req_o    (rd_req_o),
  .rd_valid_i  (rd_valid_i),
  .rd_addr_o   (rd_addr_o),
  .wr_req_o    (wr_req_o),
  .wr_ack_i    (wr_ack_i),
  .wr_addr_o   (wr_addr_o),
  .wr_byte_o   (wr_byte_o),
  .irq_valid_o (irq_valid_o),
  .irq_ready_i (irq_ready_i),
  .irq_num_o   (irq_num_o),
  .irq_server_o(irq_server_o),
  .err_valid_o (err_valid_o),
  .err_code_o  (err_code_o)
);

// File: tb/tb_msi_dispatch.sv
`timescale 1ns/1ps
module tb_msi_dispatch;
  localparam int ADDR_W = 48;
  localparam int IRQ_W  = 20;
  localparam logic [ADDR_W-1:0] BASE = 48'h0000_1000_0000;
  localparam logic [16:0] TLEN   = 17'd40;
  localparam logic [16:0] SCOUNT = 17'd48;
  localparam logic [IRQ_W-1:0] OFFS = 20'h00100;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [15:0]       data;
    logic [7:0]        dom;
    logic              frc;
    logic              big;
    logic [63:0]       entry;
  } vec_t;

  // entry: [55:48] dom, bit40 Q, [34:33] gen, bit32 P, [23:16] prio, [15:0] raw server
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{48'h100,         16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00000004_00050123}, // 00 -> P+send
    '{48'h100,         16'h0013, 8'hFF, 1'b0, 1'b0, 64'h00000005_00050123}, // 10 -> Q
    '{48'h100,         16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00000104_00050123}, // 01 drop
    '{48'h100,         16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00000105_00050123}, // 11 drop
    '{48'h100,         16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00000004_00FF0123}, // masked
    '{48'h100,         16'h0003, 8'hFF, 1'b1, 1'b0, 64'h00000105_00050123}, // force
    '{48'h050,         16'h0000, 8'hFF, 1'b0, 1'b1, 64'h00000002_0010ABCC}, // big stride
    '{48'h320,         16'h0000, 8'hFF, 1'b0, 1'b0, 64'h00000004_00050123}, // src 50 range
    '{48'h2A0,         16'h0000, 8'hFF, 1'b0, 1'b0, 64'h00000004_00050123}, // src 42 table
    '{48'h100,         16'h0003, 8'h03, 1'b0, 1'b0, 64'h00070004_00050123}, // dom mismatch
    '{48'h100,         16'h0003, 8'h07, 1'b0, 1'b0, 64'h00070004_00050123}, // dom match
    '{48'h1_0000_0070, 16'hFFE7, 8'hFF, 1'b0, 1'b0, 64'h00000004_00310ED8}  // src merge
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              msi_valid_i = 1'b0;
  logic              msi_ready_o;
  logic [ADDR_W-1:0] msi_addr_i = '0;
  logic [15:0]       msi_data_i = '0;
  logic [7:0]        msi_dom_i = 8'hFF;
  logic              msi_force_i = 1'b0;
  logic              cfg_tbl_en_i = 1'b1;
  logic              cfg_big_entry_i = 1'b0;
  logic              rd_req_o, wr_req_o, irq_valid_o, err_valid_o;
  logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
  logic              rd_valid_i = 1'b0;
  logic [63:0]       rd_data_i = '0;
  logic [7:0]        wr_byte_o;
  logic              wr_ack_i = 1'b0;
  logic              irq_ready_i = 1'b0;
  logic [13:0]       irq_server_o;
  logic [IRQ_W-1:0]  irq_num_o;
  logic [7:0]        irq_prio_o;
  logic [1:0]        err_code_o;

  msi_dispatch #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .msi_valid_i(msi_valid_i), .msi_ready_o(msi_ready_o),
    .msi_addr_i(msi_addr_i), .msi_data_i(msi_data_i),
    .msi_dom_i(msi_dom_i), .msi_force_i(msi_force_i),
    .cfg_tbl_en_i(cfg_tbl_en_i), .cfg_big_entry_i(cfg_big_entry_i),
    .cfg_tbl_base_i(BASE), .cfg_tbl_len_i(TLEN),
    .cfg_src_count_i(SCOUNT), .cfg_src_offset_i(OFFS),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_byte_o(wr_byte_o),
    .wr_ack_i(wr_ack_i),
    .irq_valid_o(irq_valid_o), .irq_ready_i(irq_ready_i),
    .irq_server_o(irq_server_o), .irq_num_o(irq_num_o), .irq_prio_o(irq_prio_o),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o)
  );

  // responder / monitor state (written only by the monitor)
  logic [63:0]       cur_entry = '0;
  int                n_rd = 0, n_wr = 0, n_irq = 0, n_err = 0;
  int                busy_bad = 0, stall_bad = 0, irq_phase = 0;
  logic [ADDR_W-1:0] last_rd = '0, last_wr = '0;
  logic [7:0]        last_byte = '0, last_prio = '0;
  logic [13:0]       last_srv = '0;
  logic [IRQ_W-1:0]  last_num = '0;
  logic [1:0]        last_err = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (rd_req_o && !rd_valid_i) begin
        n_rd++; last_rd = rd_addr_o; rd_data_i = cur_entry; rd_valid_i = 1'b1;
      end else rd_valid_i = 1'b0;
      if (wr_req_o && !wr_ack_i) begin
        n_wr++; last_wr = wr_addr_o; last_byte = wr_byte_o; wr_ack_i = 1'b1;
      end else wr_ack_i = 1'b0;
      if (irq_valid_o) begin
        if (irq_phase == 0) begin
          n_irq++; last_srv = irq_server_o; last_num = irq_num_o; last_prio = irq_prio_o;
          irq_phase = 1; irq_ready_i = 1'b0;
        end else begin
          if (irq_server_o != last_srv || irq_num_o != last_num || irq_prio_o != last_prio)
            stall_bad++;
          irq_ready_i = 1'b1;
        end
      end else begin
        irq_phase = 0; irq_ready_i = 1'b0;
      end
      if (err_valid_o) begin n_err++; last_err = err_code_o; end
      if (msi_ready_o && (rd_req_o || wr_req_o || irq_valid_o)) busy_bad++;
    end
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expectations computed from the requirements
  int                e_err, e_rd, e_wr, e_irq;
  logic [ADDR_W-1:0] e_rd_addr, e_wr_addr;
  logic [7:0]        e_byte, e_prio;
  logic [13:0]       e_srv;
  logic [IRQ_W-1:0]  e_num;
  string             e_tag;

  task automatic model(input vec_t v, input bit en);
    logic [15:0] s;
    logic [1:0]  pq;
    s = v.addr[19:4] | {11'b0, v.data[4:0]};             // R1
    e_err = 0; e_rd = 0; e_wr = 0; e_irq = 0; e_tag = "R7";
    e_rd_addr = '0; e_wr_addr = '0; e_byte = '0;
    e_srv = v.entry[15:2]; e_prio = v.entry[23:16];
    e_num = IRQ_W'(s) + OFFS;
    if ({1'b0, s} >= SCOUNT) begin e_err = 1; e_tag = "R2"; end
    else if (!en || {1'b0, s} >= TLEN) begin e_err = 2; e_tag = "R3"; end
    else begin
      e_rd = 1;
      e_rd_addr = BASE + (v.big ? (ADDR_W'(s) << 7) : (ADDR_W'(s) << 4));
      if (v.dom != 8'hFF && v.dom != v.entry[55:48]) begin e_err = 3; e_tag = "R9"; end
      else begin
        pq = v.frc ? 2'b00 : {v.entry[32], v.entry[40]};
        if (pq[0]) e_tag = "R7";
        else if (v.entry[23:16] == 8'hFF) begin
          e_wr = 1; e_wr_addr = e_rd_addr + 5; e_byte = 8'h01; e_tag = "R10";
        end else if (pq == 2'b00) begin
          e_wr = 1; e_wr_addr = e_rd_addr + 4;
          e_byte = 8'h01 | {5'b0, v.entry[34:33], 1'b0}; e_irq = 1;
          e_tag = v.frc ? "R11" : "R5";
        end else begin
          e_wr = 1; e_wr_addr = e_rd_addr + 5; e_byte = 8'h01; e_tag = "R6";
        end
      end
    end
  endtask

  task automatic run(input vec_t v, input bit en);
    int r0, w0, i0, x0;
    @(negedge clk);
    while (!msi_ready_o) @(negedge clk);
    model(v, en);
    r0 = n_rd; w0 = n_wr; i0 = n_irq; x0 = n_err;
    cur_entry = v.entry;
    cfg_big_entry_i = v.big; cfg_tbl_en_i = en;
    msi_addr_i = v.addr; msi_data_i = v.data; msi_dom_i = v.dom; msi_force_i = v.frc;
    msi_valid_i = 1'b1;
    @(negedge clk);
    msi_valid_i = 1'b0;
    repeat (12) @(negedge clk);
    chk((n_err - x0) == (e_err != 0) && (e_err == 0 || last_err == 2'(e_err)),
        {e_tag, " error"}, 64'(last_err), 64'(e_err));
    chk((n_rd - r0) == e_rd && (e_rd == 0 || last_rd == e_rd_addr),
        "R4 read addr", 64'(last_rd), 64'(e_rd_addr));
    chk((n_wr - w0) == e_wr && (e_wr == 0 || (last_wr == e_wr_addr && last_byte == e_byte)),
        {e_tag, " byte write"}, {last_wr, last_byte}, {e_wr_addr, e_byte});
    chk((n_irq - i0) == e_irq &&
        (e_irq == 0 || (last_srv == e_srv && last_num == e_num && last_prio == e_prio)),
        {e_tag, " R8 R1 present"}, {last_srv, last_num, last_prio}, {e_srv, e_num, e_prio});
    cfg_tbl_en_i = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(msi_ready_o && !rd_req_o && !wr_req_o && !irq_valid_o && !err_valid_o,
        "R12 reset state", {rd_req_o, wr_req_o, irq_valid_o, err_valid_o, msi_ready_o}, 64'h1);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b1);
    // table disabled, otherwise valid source
    run(VECS[0], 1'b0);
    // skip value passes even with mismatching domain field
    run('{48'h100, 16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00550004_00050123}, 1'b1);
    // last table entry and first out-of-range one
    run('{48'h270, 16'h0000, 8'hFF, 1'b0, 1'b0, 64'h00000004_00050123}, 1'b1);
    run('{48'h280, 16'h0000, 8'hFF, 1'b0, 1'b0, 64'h00000004_00050123}, 1'b1);
    // masked and pending: still set Q
    run('{48'h100, 16'h0003, 8'hFF, 1'b0, 1'b0, 64'h00000005_00FF0123}, 1'b1);
    chk(busy_bad == 0, "R12 ready while busy", 64'(busy_bad), 64'h0);
    chk(stall_bad == 0, "R8 stalled fields changed", 64'(stall_bad), 64'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule